// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Byte Cache

This block is a small data cache that sits between a processor-side request port and a backing memory. It holds 64 bytes of data as eight sets of two 4-byte lines. A request carries a 13-bit byte address. The address is split into a tag, a set index and a byte offset. The two ways of the selected set are compared at the same time. On a hit the addressed byte comes back in the same cycle as the request.

On a miss the cache picks a way to replace. An empty way in the set is taken first. If both ways are full, the least recently used way is replaced. If that victim line has been written, it is sent back to memory before the new line is fetched. Writes change only the cached line and mark it dirty. A write miss first brings in the whole line and then merges the written byte. The backing memory moves one full line per transfer using a request/acknowledge handshake.

The processor holds its request, address, write flag and write data steady until it sees `cpu_ready`.

Top module: `cache2w`

## Requirements
- R1: The byte address splits into tag = bits [12:5], set index = bits [4:2] and byte offset = bits [1:0]. The memory-side address is the 11-bit line address {tag, set index}, and for a refill it equals the request address bits [12:2].
- R2: A request hits when a way of the selected set is valid and its stored tag equals the address tag. A hit raises `cpu_ready` and `cpu_hit` in the same cycle as the request and issues no memory transfer.
- R3: The returned byte is line bits [8*offset+7 : 8*offset]. Offset 0 is the least significant byte of the 32-bit line word.
- R4: On a miss, `cpu_ready` stays low until any writeback and the refill are both acknowledged. The response (`cpu_ready`=1, `cpu_hit`=0) comes in the cycle after the refill acknowledge.
- R5: On a miss, an invalid way of the selected set is filled before any valid way is replaced. Way 0 is taken when both ways are empty.
- R6: When both ways are valid, the least recently used way is replaced. Every hit and every fill makes the other way the next victim. For three tags A, B, C in one set, the sequence A, B, A, C, A, B gives miss, miss, hit, miss, hit, miss.
- R7: A write updates only the cached byte and marks the line dirty. A write hit causes no memory transfer.
- R8: A dirty victim is written to memory (`mem_we`=1, address {victim tag, set}, data = the whole line) before the refill. A clean victim is dropped without a write.
- R9: A write miss fetches the full line first, then merges the written byte. A later read of the line returns the new byte at that offset and the fetched bytes everywhere else.
- R10: Reset clears all valid, dirty and LRU state. After reset the block is idle with no memory request, and the first access to any address misses, even one whose tag bits are zero.
- R11: `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack`. It is low when the processor response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | 13 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Byte read, valid with `cpu_ready` |
| cpu_hit | output | 1 | Request was a hit, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = writeback of a line, 0 = refill |
| mem_addr | output | 11 | Line address {tag, set} |
| mem_wdata | output | 32 | Line being written back |
| mem_rdata | input | 32 | Refill line, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The bench aims at the points where a cache policy usually breaks:

- **Tag bits match in an empty way after reset.** A design that ignored the valid bit would report a false hit here.
- **The three-tag LRU sequence.** A victim choice that ignores recency would evict the line just used, and so turn the fifth access into a miss.
- **A written line evicted and then fetched again.** A design that skipped the writeback, or wrote back clean lines, would show a wrong writeback count or lose the written byte.
- **Write misses.** If a write miss does not fetch the line before merging, the other bytes of the line come back wrong.

Random traffic over four tags per set, with random memory delay, compares every hit flag, read byte and writeback against a reference model of the same policy.

// File: rtl/cache2w_pkg.sv
// Shared geometry and controller state encoding for the two-way cache.
package cache2w_pkg;
    localparam int TAG_W  = 8;
    localparam int IDX_W  = 3;
    localparam int OFF_W  = 2;
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
    localparam int LINE_W = 8 << OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_DONE
    } cstate_e;
endpackage

// File: rtl/cache2w_tags.sv
// Tag, valid, dirty and per-set LRU storage for two ways.
// Compares both ways of the addressed set in parallel and proposes a victim:
// an invalid way first (way 0 before way 1), otherwise the LRU way.
// Assumes fill and touch are never requested in the same cycle.
module cache2w_tags #(
    parameter int TAG_W = 8,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic [TAG_W-1:0]   tag,
    input  logic               fill_en,
    input  logic               fill_way,
    input  logic               touch_en,
    input  logic               touch_way,
    input  logic               touch_dirty,
    output logic [1:0]         hit_vec,
    output logic               vic_way,
    output logic [1:0]         dirty_of,
    output logic [2*TAG_W-1:0] tag_of
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  valid_q [2];
    logic [SETS-1:0]  dirty_q [2];
    logic [TAG_W-1:0] tag_q   [2][SETS];
    logic [SETS-1:0]  lru_q;

    // Per-way comparator and read-out of the addressed set.
    for (genvar w = 0; w < 2; w++) begin : g_way
        assign hit_vec[w]                = valid_q[w][idx] && (tag_q[w][idx] == tag);
        assign dirty_of[w]               = dirty_q[w][idx];
        assign tag_of[w*TAG_W +: TAG_W]  = tag_q[w][idx];
    end

    // Victim choice: empty way first, then the least recently used one.
    always_comb begin
        if (!valid_q[0][idx])      vic_way = 1'b0;
        else if (!valid_q[1][idx]) vic_way = 1'b1;
        else                       vic_way = lru_q[idx];
    end

    // State update on reset, line fill and access touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 2; w++) begin
                valid_q[w] <= '0;
                dirty_q[w] <= '0;
                for (int s = 0; s < SETS; s++) tag_q[w][s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_way][idx] <= 1'b1;
                dirty_q[fill_way][idx] <= 1'b0;
                tag_q[fill_way][idx]   <= tag;
            end
            if (touch_en) begin
                lru_q[idx] <= ~touch_way;
                if (touch_dirty) dirty_q[touch_way][idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache2w_data.sv
// Line data storage for two ways with byte read, byte merge and full-line
// fill. Line contents are not reset; the valid bits guard every use.
module cache2w_data #(
    parameter int IDX_W = 3,
    parameter int OFF_W = 2
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        idx,
    input  logic [OFF_W-1:0]        off,
    input  logic                    rd_way,
    input  logic                    fill_en,
    input  logic                    fill_way,
    input  logic [(8<<OFF_W)-1:0]   fill_line,
    input  logic                    wr_en,
    input  logic                    wr_way,
    input  logic [7:0]              wr_byte,
    output logic [(8<<OFF_W)-1:0]   rd_line,
    output logic [7:0]              rd_byte
);
    localparam int SETS   = 1 << IDX_W;
    localparam int LINE_W = 8 << OFF_W;

    logic [LINE_W-1:0] line_q [2][SETS];

    // Way select of the addressed line and byte select by offset.
    assign rd_line = line_q[rd_way][idx];
    assign rd_byte = rd_line[{off, 3'b000} +: 8];

    // Line write: full refill or a single-byte merge.
    always_ff @(posedge clk) begin
        if (fill_en)    line_q[fill_way][idx] <= fill_line;
        else if (wr_en) line_q[wr_way][idx][{off, 3'b000} +: 8] <= wr_byte;
    end
endmodule

// File: rtl/cache2w_ctrl.sv
// Miss sequencer: IDLE serves hits; a miss latches the victim way and goes
// through an optional writeback, the refill, and a one-cycle response state
// in which the access is replayed against the filled line.
module cache2w_ctrl
    import cache2w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic hit_any,
    input  logic vic_way,
    input  logic vic_dirty,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic cpu_hit,
    output logic mem_req,
    output logic mem_we,
    output logic fill_en,
    output logic touch_en,
    output logic in_wb,
    output logic vic_q
);
    cstate_e state_q;

    // State and victim register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vic_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_req && !hit_any) begin
                    vic_q   <= vic_way;
                    state_q <= vic_dirty ? ST_WB : ST_FILL;
                end
                ST_WB:   if (mem_ack) state_q <= ST_FILL;
                ST_FILL: if (mem_ack) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode per state.
    always_comb begin
        cpu_ready = 1'b0;
        cpu_hit   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_en   = 1'b0;
        touch_en  = 1'b0;
        in_wb     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = cpu_req && hit_any;
                cpu_hit   = cpu_req && hit_any;
                touch_en  = cpu_req && hit_any;
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                in_wb   = 1'b1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                touch_en  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cache2w.sv
// Two-way set-associative write-back byte cache, 8 sets of 4-byte lines.
// Assumes the processor holds request fields steady until cpu_ready, and the
// memory returns refill data together with a one-cycle mem_ack.
module cache2w
    import cache2w_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic [7:0]              cpu_rdata,
    output logic                    cpu_hit,
    output logic                    cpu_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [TAG_W+IDX_W-1:0]  mem_addr,
    output logic [LINE_W-1:0]       mem_wdata,
    input  logic [LINE_W-1:0]       mem_rdata,
    input  logic                    mem_ack
);
    logic [TAG_W-1:0]   a_tag;
    logic [IDX_W-1:0]   a_idx;
    logic [OFF_W-1:0]   a_off;
    logic [1:0]         hit_vec;
    logic [1:0]         dirty_of;
    logic [2*TAG_W-1:0] tag_of;
    logic               vic_way, vic_q, in_wb, fill_en, touch_en, rd_way;
    logic [TAG_W-1:0]   vic_tag;

    // Address split.
    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx = cpu_addr[OFF_W +: IDX_W];
    assign a_off = cpu_addr[OFF_W-1:0];

    // Way and address muxing for writeback versus lookup.
    assign rd_way   = in_wb ? vic_q : hit_vec[1];
    assign vic_tag  = vic_q ? tag_of[2*TAG_W-1:TAG_W] : tag_of[TAG_W-1:0];
    assign mem_addr = {(in_wb ? vic_tag : a_tag), a_idx};

    cache2w_tags #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (a_idx),
        .tag        (a_tag),
        .fill_en    (fill_en),
        .fill_way   (vic_q),
        .touch_en   (touch_en),
        .touch_way  (hit_vec[1]),
        .touch_dirty(cpu_we),
        .hit_vec    (hit_vec),
        .vic_way    (vic_way),
        .dirty_of   (dirty_of),
        .tag_of     (tag_of)
    );

    cache2w_data #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk      (clk),
        .idx      (a_idx),
        .off      (a_off),
        .rd_way   (rd_way),
        .fill_en  (fill_en),
        .fill_way (vic_q),
        .fill_line(mem_rdata),
        .wr_en    (touch_en && cpu_we),
        .wr_way   (hit_vec[1]),
        .wr_byte  (cpu_wdata),
        .rd_line  (mem_wdata),
        .rd_byte  (cpu_rdata)
    );

    cache2w_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .hit_any  (|hit_vec),
        .vic_way  (vic_way),
        .vic_dirty(dirty_of[vic_way]),
        .mem_ack  (mem_ack),
        .cpu_ready(cpu_ready),
        .cpu_hit  (cpu_hit),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .fill_en  (fill_en),
        .touch_en (touch_en),
        .in_wb    (in_wb),
        .vic_q    (vic_q)
    );
endmodule

// File: rtl/cache2w_chk.sv
// Port-level protocol checker for cache2w, attached by bind below.
module cache2w_chk
    import cache2w_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   cpu_hit,
    input logic                   cpu_ready,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [TAG_W+IDX_W-1:0] mem_addr,
    input logic                   mem_ack
);
    // Memory request holds its fields until acknowledged.
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // A finished writeback is followed by a refill request.
    assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // Response with hit low comes right after the refill acknowledge.
    assert_resp_after_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> cpu_ready && !cpu_hit);

    // A hit never overlaps a memory transfer.
    assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_hit |-> !mem_req);

    // Refill line address is the request address without its offset.
    assert_fill_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr == cpu_addr[ADDR_W-1:OFF_W]);

    // Responses are only given to a pending request.
    assert_ready_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind cache2w cache2w_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .cpu_hit  (cpu_hit),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/test_cache2w.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a behavioural model of the same replacement policy.
module test_cache2w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_hit, cpu_ready, mem_req, mem_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cache2w i_cache2w (.*);

    // Backing memory model with random acknowledge delay.
    logic [31:0] bmem [2048];
    int          dly;
    int          wb_cnt;
    logic [10:0] wb_addr;
    logic [31:0] wb_data;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) bmem[i] <= i * 32'h9E3779B1 ^ 32'h5A5A0000;
            mem_ack <= 1'b0; mem_rdata <= '0; dly <= 0; wb_cnt <= 0;
            wb_addr <= '0; wb_data <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (dly == 0) begin
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        bmem[mem_addr] <= mem_wdata;
                        wb_cnt <= wb_cnt + 1; wb_addr <= mem_addr; wb_data <= mem_wdata;
                    end else mem_rdata <= bmem[mem_addr];
                    dly <= int'($urandom % 3);
                end else dly <= dly - 1;
            end
        end
    end

    // Reference model state.
    logic [31:0] rmem [2048];
    logic        rv [2][8];
    logic        rd [2][8];
    logic [7:0]  rt [2][8];
    logic [31:0] rl_data [2][8];
    logic        rlru [8];

    task automatic ref_reset();
        for (int i = 0; i < 2048; i++) rmem[i] = i * 32'h9E3779B1 ^ 32'h5A5A0000;
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 8; s++) begin
                rv[w][s] = 1'b0; rd[w][s] = 1'b0; rt[w][s] = '0; rl_data[w][s] = '0;
            end
        for (int s = 0; s < 8; s++) rlru[s] = 1'b0;
    endtask

    task automatic ref_access(input logic [12:0] a, input logic we, input logic [7:0] wd,
                              output logic ehit, output logic [7:0] erd, output logic ewb,
                              output logic [10:0] ewb_addr, output logic [31:0] ewb_data);
        logic [7:0] t = a[12:5];
        int s = int'(a[4:2]);
        int o = int'(a[1:0]);
        int w = -1;
        ehit = 1'b0; ewb = 1'b0; ewb_addr = '0; ewb_data = '0;
        for (int k = 0; k < 2; k++) if (rv[k][s] && rt[k][s] == t) w = k;
        if (w >= 0) ehit = 1'b1;
        else begin
            w = !rv[0][s] ? 0 : (!rv[1][s] ? 1 : int'(rlru[s]));
            if (rv[w][s] && rd[w][s]) begin
                ewb = 1'b1; ewb_addr = {rt[w][s], a[4:2]}; ewb_data = rl_data[w][s];
                rmem[ewb_addr] = ewb_data;
            end
            rl_data[w][s] = rmem[{t, a[4:2]}];
            rv[w][s] = 1'b1; rt[w][s] = t; rd[w][s] = 1'b0;
        end
        erd = rl_data[w][s][o*8 +: 8];
        if (we) begin
            rl_data[w][s][o*8 +: 8] = wd;
            rd[w][s] = 1'b1;
        end
        rlru[s] = (w == 0);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // One processor access, checked against the model. hit_req names the
    // requirement the hit/miss outcome demonstrates.
    task automatic access(input logic [12:0] a, input logic we, input logic [7:0] wd,
                          input string hit_req);
        logic ehit, ewb, ghit;
        logic [7:0] erd, grd;
        logic [10:0] ewa;
        logic [31:0] ewd;
        int wb0, waited;
        ref_access(a, we, wd, ehit, erd, ewb, ewa, ewd);
        wb0 = wb_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        waited = 0;
        #2;
        while (!cpu_ready) begin
            @(negedge clk); #2;
            waited++;
        end
        ghit = cpu_hit; grd = cpu_rdata;
        check(hit_req, "hit flag", 32'(ghit), 32'(ehit));
        if (!we) check("R3", "read byte (R1 split)", 32'(grd), 32'(erd));
        if (ehit) check("R2", "hit latency", 32'(waited), 32'd0);
        else      check("R4", "miss stalls ready", 32'(waited > 0), 32'd1);
        check("R11", "mem_req low at response", 32'(mem_req), 32'd0);
        check("R8", "writeback count", 32'(wb_cnt - wb0), 32'(ewb));
        if (ewb) begin
            check("R8", "writeback address", 32'(wb_addr), 32'(ewa));
            check("R8", "writeback line", wb_data, ewd);
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    function automatic logic [12:0] mk(input int t, input int s, input int o);
        return {8'(t), 3'(s), 2'(o)};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        ref_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        check("R10", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
        check("R10", "mem_req after reset", 32'(mem_req), 32'd0);
        // R10: zero tag bits in an invalid way still miss
        access(mk(0, 0, 0), 1'b0, 8'h00, "R10");
        // R5: second tag in an empty set takes the free way, both then hit
        access(mk(5, 6, 1), 1'b0, 8'h00, "R5");
        access(mk(9, 6, 2), 1'b0, 8'h00, "R5");
        access(mk(5, 6, 3), 1'b0, 8'h00, "R5");
        access(mk(9, 6, 0), 1'b0, 8'h00, "R5");
        // R6: A B A C A B -> miss miss hit miss hit miss
        access(mk(3, 1, 0), 1'b0, 8'h00, "R6");
        access(mk(7, 1, 1), 1'b0, 8'h00, "R6");
        access(mk(3, 1, 2), 1'b0, 8'h00, "R6");
        access(mk(9, 1, 3), 1'b0, 8'h00, "R6");
        access(mk(3, 1, 0), 1'b0, 8'h00, "R6");
        access(mk(7, 1, 1), 1'b0, 8'h00, "R6");
        // R9: write miss allocates, merged byte reads back, neighbours fetched
        access(mk(1, 2, 2), 1'b1, 8'hC3, "R9");
        access(mk(1, 2, 2), 1'b0, 8'h00, "R9");
        access(mk(1, 2, 1), 1'b0, 8'h00, "R9");
        // R7: write hit, no memory traffic
        access(mk(1, 2, 0), 1'b1, 8'h3C, "R7");
        // R8: fill other way, then evict dirty LRU line and fetch it again
        access(mk(2, 2, 0), 1'b0, 8'h00, "R8");
        access(mk(4, 2, 0), 1'b0, 8'h00, "R8");
        access(mk(1, 2, 2), 1'b0, 8'h00, "R8");
        access(mk(1, 2, 0), 1'b0, 8'h00, "R8");
        // Random traffic over four tags per set
        for (int n = 0; n < 400; n++) begin
            access(mk(int'($urandom % 4), int'($urandom % 8), int'($urandom % 4)),
                   1'($urandom % 2), 8'($urandom), "R6");
        end
        summary();
        $finish;
    end
endmodule